// File: doc/BRIEF.md
# Port A Input Timer Front End

This block sits behind an 8-bit general-purpose port whose pins can be refreshed from outside the core. Whenever a pin-update strobe arrives, the new pin values are merged into the port register. Bit 7 is held when the control field marks it as an output. The change pattern between the old and new port value then drives two timer functions.

The first function is an 8-bit event counter clocked by a chosen edge of bit 7. When the counter wraps to zero it raises an overflow flag. The second function is three input-capture channels. Each channel watches one pin through its own 2-bit edge selector. Every capture raises a per-channel flag and a one-cycle event pulse that identifies the channel. Any overflow or capture also pulses a request for the interrupt logic to re-evaluate its pending state. Flags stay set until a write-one-to-clear strobe removes them.

The block has no state machine. Its control is a single update path: the strobe is sampled on a clock edge, and the port register, counter, flags and event pulses all change together on that edge.

Top module: `pa_timer_input`

## Requirements
- R1: `port_q` changes only on a clock edge where `pin_upd` is 1. It then shows `pin_val` on every bit that is an input.
- R2: While `dir7_out` is 1, bit 7 of `port_q` keeps its previous value on an update. While `dir7_out` is 0, bit 7 follows `pin_val[7]`.
- R3: The event counter `evt_cnt` can step only when `cnt_en` is 1 and `cnt_gate` is 0. Otherwise it holds its value.
- R4: With `cnt_rise` at 1, the counter adds one when an update changes `port_q[7]` from 0 to 1. With `cnt_rise` at 0, it adds one when bit 7 changes from 1 to 0. An update that leaves bit 7 unchanged never counts.
- R5: An increment from 255 to 0 sets `ovf_flag` and pulses `reeval` for one cycle.
- R6: Capture channel i (0, 1, 2) watches `port_q` bit 3-i. Its edge selector is `cap_sel[2i+1:2i]`.
- R7: The edge selector encoding is as follows. 0 means the channel is off. 1 captures when the watched bit changes to 1. 2 captures when it changes to 0. 3 captures when it changes in either direction.
- R8: A capture on channel i sets `cap_flag[i]`, pulses `cap_hit[i]` for one cycle and pulses `reeval`. All three appear in the cycle in which `port_q` shows the new value.
- R9: A 1 on `cap_clr[i]` clears `cap_flag[i]`, and a 1 on `ovf_clr` clears `ovf_flag`. A 0 on a clear bit leaves its flag as it is. When a set and a clear reach the same flag in the same cycle, the set wins.
- R10: After reset, `port_q`, `evt_cnt`, all flags, `cap_hit` and `reeval` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_upd | input | 1 | Strobe: merge `pin_val` into the port this cycle |
| pin_val | input | 8 | New external pin values |
| dir7_out | input | 1 | Bit 7 is an output and is protected from updates |
| cnt_en | input | 1 | Event counter enable |
| cnt_gate | input | 1 | Counter gated-time mode; event counting is suppressed when 1 |
| cnt_rise | input | 1 | 1: count rising edges of bit 7; 0: count falling edges |
| cap_sel | input | 6 | Three 2-bit edge selectors, channel i at [2i+1:2i] |
| cap_clr | input | 3 | Write-one-to-clear strobes for the capture flags |
| ovf_clr | input | 1 | Write-one-to-clear strobe for the overflow flag |
| port_q | output | 8 | Port register |
| evt_cnt | output | 8 | Event counter value |
| ovf_flag | output | 1 | Counter overflow flag |
| cap_flag | output | 3 | Capture flags, one per channel |
| cap_hit | output | 3 | One-cycle capture event, the set bit names the channel |
| reeval | output | 1 | One-cycle request to re-evaluate interrupts |

## Verification
A wrong stored port value changes the next change pattern. The error therefore shows up within one update as a missed or spurious count or capture, or directly as a wrong `port_q`. A counter that is off by one shows in `evt_cnt` in the same cycle. A stuck flag shows when a clear strobe fails to drop it one cycle later. A wrong channel-to-pin mapping shows as `cap_hit` on the wrong bit in the first cycle after the edge.

// File: rtl/pa_tmr_pkg.sv
package pa_tmr_pkg;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_ANY  = 2'd3
    } edge_sel_e;

    // Decide whether a changed bit matches the selected edge.
    function automatic logic edge_match(edge_sel_e sel, logic changed, logic now_val);
        logic hit;
        hit = 1'b0;
        unique case (sel)
            EDGE_OFF:  hit = 1'b0;
            EDGE_RISE: hit = changed & now_val;
            EDGE_FALL: hit = changed & ~now_val;
            EDGE_ANY:  hit = changed;
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/pa_port_merge.sv
module pa_port_merge #(
    parameter int W       = 8,
    parameter int DIR_BIT = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd,
    input  logic [W-1:0] pin_val,
    input  logic         dir_out,
    output logic [W-1:0] port_q,
    output logic [W-1:0] nxt_val,
    output logic [W-1:0] chg
);
    localparam logic [W-1:0] DIR_MASK = W'(1) << DIR_BIT;

    logic [W-1:0] in_mask;

    always_comb begin
        in_mask = dir_out ? ~DIR_MASK : '1;
        nxt_val = (pin_val & in_mask) | (port_q & ~in_mask);
        chg     = upd ? (nxt_val ^ port_q) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   port_q <= '0;
        else if (upd) port_q <= nxt_val;
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(port_q)); // R1
    AST_DIR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && dir_out) |=> port_q[DIR_BIT] == $past(port_q[DIR_BIT])); // R2

endmodule

// File: rtl/pa_event_counter.sv
module pa_event_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chg_bit,
    input  logic             new_bit,
    input  logic             en,
    input  logic             gate_mode,
    input  logic             rise,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] cnt_q,
    output logic             ovf_q,
    output logic             wrap_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic inc, wrap;

    always_comb begin
        inc  = en & ~gate_mode & chg_bit & (rise ? new_bit : ~new_bit);
        wrap = inc & (cnt_q == CNT_MAX);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            ovf_q  <= 1'b0;
            wrap_q <= 1'b0;
        end else begin
            if (inc) cnt_q <= cnt_q + 1'b1;
            ovf_q  <= wrap | (ovf_q & ~ovf_clr);
            wrap_q <= wrap;
        end
    end

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(en && !gate_mode) |=> $stable(cnt_q)); // R3
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_q |-> (cnt_q == '0 && ovf_q)); // R5

endmodule

// File: rtl/pa_capture_chan.sv
module pa_capture_chan
    import pa_tmr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      chg,
    input  logic      now_val,
    input  edge_sel_e sel,
    input  logic      clr,
    output logic      flag_q,
    output logic      hit_q
);
    logic hit;

    always_comb hit = edge_match(sel, chg, now_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            hit_q  <= 1'b0;
        end else begin
            flag_q <= hit | (flag_q & ~clr);
            hit_q  <= hit;
        end
    end

    AST_HIT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        hit_q |-> flag_q); // R8
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == EDGE_OFF) |=> !hit_q); // R7
    AST_CLR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !chg) |=> !flag_q); // R9

endmodule

// File: rtl/pa_timer_input.sv
module pa_timer_input
    import pa_tmr_pkg::*;
#(
    parameter int W        = 8,
    parameter int CNT_W    = 8,
    parameter int N_CAP    = 3,
    parameter int CAP_TOP  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_upd,
    input  logic [W-1:0]     pin_val,
    input  logic             dir7_out,
    input  logic             cnt_en,
    input  logic             cnt_gate,
    input  logic             cnt_rise,
    input  logic [2*N_CAP-1:0] cap_sel,
    input  logic [N_CAP-1:0] cap_clr,
    input  logic             ovf_clr,
    output logic [W-1:0]     port_q,
    output logic [CNT_W-1:0] evt_cnt,
    output logic             ovf_flag,
    output logic [N_CAP-1:0] cap_flag,
    output logic [N_CAP-1:0] cap_hit,
    output logic             reeval
);
    localparam int GATE_BIT = W - 1;

    logic [W-1:0] nxt_val, chg;
    logic         wrap_q;

    pa_port_merge #(.W(W), .DIR_BIT(GATE_BIT)) u_merge (
        .clk(clk), .rst_n(rst_n), .upd(pin_upd), .pin_val(pin_val),
        .dir_out(dir7_out), .port_q(port_q), .nxt_val(nxt_val), .chg(chg)
    );

    pa_event_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .chg_bit(chg[GATE_BIT]),
        .new_bit(nxt_val[GATE_BIT]), .en(cnt_en), .gate_mode(cnt_gate),
        .rise(cnt_rise), .ovf_clr(ovf_clr), .cnt_q(evt_cnt),
        .ovf_q(ovf_flag), .wrap_q(wrap_q)
    );

    for (genvar i = 0; i < N_CAP; i++) begin : g_cap
        localparam int PIN = CAP_TOP - i;
        pa_capture_chan u_chan (
            .clk(clk), .rst_n(rst_n), .chg(chg[PIN]), .now_val(nxt_val[PIN]),
            .sel(edge_sel_e'(cap_sel[2*i +: 2])), .clr(cap_clr[i]),
            .flag_q(cap_flag[i]), .hit_q(cap_hit[i])
        );
    end

    always_comb reeval = wrap_q | (|cap_hit);

    AST_REEVAL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        reeval |-> $past(pin_upd)); // R8
    AST_HIT_ONEPORT: assert property (@(posedge clk) disable iff (!rst_n)
        (|cap_hit) |-> port_q != $past(port_q)); // R6

endmodule

// File: tb/tb_pa_timer_input.sv
`timescale 1ns/100ps
module tb_pa_timer_input;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_upd = 1'b0;
    logic [7:0] pin_val = '0;
    logic       dir7_out = 1'b0, cnt_en = 1'b0, cnt_gate = 1'b0, cnt_rise = 1'b1;
    logic [5:0] cap_sel = '0;
    logic [2:0] cap_clr = '0;
    logic       ovf_clr = 1'b0;
    logic [7:0] port_q, evt_cnt;
    logic       ovf_flag, reeval;
    logic [2:0] cap_flag, cap_hit;

    int vectors = 0;
    int misses  = 0;

    // reference model state
    int m_port = 0, m_cnt = 0, m_ovf = 0, m_flags = 0, m_hit = 0, m_re = 0;

    always #2.5 clk = ~clk;

    pa_timer_input dut (
        .clk(clk), .rst_n(rst_n), .pin_upd(pin_upd), .pin_val(pin_val),
        .dir7_out(dir7_out), .cnt_en(cnt_en), .cnt_gate(cnt_gate),
        .cnt_rise(cnt_rise), .cap_sel(cap_sel), .cap_clr(cap_clr),
        .ovf_clr(ovf_clr), .port_q(port_q), .evt_cnt(evt_cnt),
        .ovf_flag(ovf_flag), .cap_flag(cap_flag), .cap_hit(cap_hit),
        .reeval(reeval)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_port = 0; m_cnt = 0; m_ovf = 0; m_flags = 0; m_hit = 0; m_re = 0;
        end else begin
            int ovf_set;
            ovf_set = 0; m_hit = 0; m_re = 0;
            if (pin_upd) begin
                int nv, delta;
                nv = dir7_out ? ((pin_val & 'h7f) | (m_port & 'h80)) : pin_val;
                delta = nv ^ m_port;
                if (cnt_en && !cnt_gate && delta[7] && (cnt_rise ? nv[7] : !nv[7])) begin
                    m_cnt = (m_cnt + 1) % 256;
                    if (m_cnt == 0) begin ovf_set = 1; m_re = 1; end
                end
                for (int i = 0; i < 3; i++) begin
                    int b, s;
                    b = 3 - i;
                    s = (cap_sel >> (2*i)) & 3;
                    if (delta[b] && (s == 3 || (s == 1 && nv[b]) || (s == 2 && !nv[b]))) begin
                        m_hit = m_hit | (1 << i);
                        m_re = 1;
                    end
                end
                m_port = nv;
            end
            m_flags = (m_flags & ~int'(cap_clr)) | m_hit;
            m_ovf   = ovf_clr ? ovf_set : (m_ovf | ovf_set);
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        if (act != exp) begin
            misses++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        vectors++;
        check("R1", "port_q", int'(port_q), m_port);
        check("R3", "evt_cnt", int'(evt_cnt), m_cnt);
        check("R5", "ovf_flag", int'(ovf_flag), m_ovf);
        check("R8", "cap_flag", int'(cap_flag), m_flags);
        check("R8", "cap_hit", int'(cap_hit), m_hit);
        check("R5", "reeval", int'(reeval), m_re);
        pin_upd = 1'b0; cap_clr = '0; ovf_clr = 1'b0;
    endtask

    task automatic upd(input logic [7:0] v);
        pin_upd = 1'b1; pin_val = v;
        tick();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        // R10: reset state
        tick(); tick();
        rst_n = 1'b1;
        tick();
        // R1: basic merge and idle hold
        upd(8'h5a); tick(); tick(); upd(8'ha5);
        // R2: bit 7 protected while output
        dir7_out = 1'b1; upd(8'h00); upd(8'h7f); upd(8'hff);
        dir7_out = 1'b0; upd(8'h00);
        // R4: rising edge counting, steady bit 7 does not count
        cnt_en = 1'b1; cnt_rise = 1'b1;
        upd(8'h80); upd(8'h80); upd(8'h00); upd(8'h80);
        // R4: falling edge counting
        cnt_rise = 1'b0; upd(8'h00); upd(8'h80); upd(8'h00);
        // R3: gated mode and disable hold the counter
        cnt_gate = 1'b1; upd(8'h80); upd(8'h00);
        cnt_gate = 1'b0; cnt_en = 1'b0; upd(8'h80); upd(8'h00);
        // R5: wrap through 255 -> 0, then clear the flag (R9)
        cnt_en = 1'b1; cnt_rise = 1'b1;
        for (int k = 0; k < 512; k++) upd(k[0] ? 8'h00 : 8'h80);
        tick(); ovf_clr = 1'b1; tick(); tick();
        // R6 R7: each selector on each channel
        cnt_en = 1'b0;
        for (int s = 0; s < 4; s++) begin
            cap_sel = {3{s[1:0]}};
            upd(8'h0e); upd(8'h00); upd(8'h08); upd(8'h04); upd(8'h02); upd(8'h00);
            cap_clr = 3'b111; tick();
        end
        // R6: mixed selectors per channel
        cap_sel = 6'b11_10_01;
        upd(8'h0e); upd(8'h00); cap_clr = 3'b010; tick();
        // R9: set wins over clear on the same cycle; zero bits leave flags
        cap_sel = 6'b11_11_11;
        upd(8'h0e); cap_clr = 3'b111; pin_upd = 1'b1; pin_val = 8'h00; tick();
        cap_clr = 3'b000; tick();
        // random mix of everything
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] r;
            r = $urandom;
            dir7_out = r[8]; cnt_en = r[9] | r[10]; cnt_gate = r[11] & r[12];
            cnt_rise = r[13]; cap_sel = r[19:14];
            cap_clr = r[22:20] & {3{r[23]}}; ovf_clr = r[24] & r[25];
            pin_upd = r[26] | r[27]; pin_val = r[7:0];
            tick();
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule